// File: doc/BRIEF.md
# Serial Flash Status Register Write Engine

This block is the target-side logic of a serial flash device that handles the command for loading a new value into the 16-bit status register. It watches a frame bounded by an active-low select. It decodes the opcode and assembles one or two data bytes from either a single data line or four data lines. When the select is released it decides whether to commit. A commit changes only the writable fields, sets the busy flag, and starts a self-timed busy window. At the end of that window the busy flag and the write-enable flag both clear.

The block also decodes the write-enable opcode, because that opcode arms the write-enable flag that every status write needs. The full status word, including the busy flag, is always visible on a parallel output, so a host can poll it while the busy window runs. The serial clock is the block clock: each rising edge with select low carries one bit in single-line mode, or one nibble in four-line mode.

Top module: `srw_top`

## Requirements
- R1: After reset `status_o` reads 0x0000.
- R2: The opcode 0x06 with exactly 8 opcode bits, while not busy, sets bit 1 (write-enable flag) on the select release. In four-line mode the opcode takes two nibbles, the high nibble first.
- R3: The write opcode 0x01 has no effect unless bit 1 was already 1.
- R4: In single-line mode, data bit k (k counted from 0 after the opcode) lands in status bit 7-k for k<8 and in bit 23-k for 8<=k<16. A 16-bit commit replaces every bit except 15, 10, 1 and 0.
- R5: A single-line commit with 8 data bits writes bits 7..2 and clears bit 14 and bit 9. Bits 13..10, bit 8 and bit 15 keep their values.
- R6: In four-line mode the data nibbles arrive on io_in[3:0] in the order bits 7..4, 3..0, 15..12, 11..8. A 16-bit commit follows the rule of R4.
- R7: A four-line commit with 8 data bits writes bits 7..2 and clears bit 14, while bit 9 keeps its value.
- R8: A release after any data bit count other than 8 or 16 leaves the status unchanged and starts no busy window.
- R9: A commit sets bit 0 on the clock edge that sees the select high. Bit 0 stays 1 for exactly TW_CYCLES edges, and bits 0 and 1 clear together on the following edge. The status stays readable throughout.
- R10: A write is refused while bit 8 is 0, bit 7 is 1 and `wp_n` is low. With `wp_n` high the same write is accepted.
- R11: Any frame that is released while bit 0 is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, also drives the busy timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| qpi_mode | input | 1 | 1 selects four-line transfers, 0 selects single-line |
| wp_n | input | 1 | Active-low write-protect pin |
| io_in | input | 4 | Data lines; single-line mode uses io_in[0] |
| status_o | output | 16 | Current status word, bit 0 busy, bit 1 write-enable |

## Verification
The hardest state to reach from the ports is a refused write under the protect rule. It needs bit 7 set and bit 8 clear, and those can only be loaded by an earlier accepted write that has finished its busy window. The bench therefore first commits that pattern with the protect pin high. It then re-arms the write-enable flag, drops `wp_n`, and shows that the next write leaves the status word unchanged.

A sweep then walks many data words across both line modes and both lengths, with the protect pin toggling. Written values sometimes enter and leave the protected state on their own, so refusals and acceptances come from the block's own history.

// File: rtl/srw_pkg.sv
package srw_pkg;
   localparam int SR_W   = 16;
   localparam int B_WIP  = 0;
   localparam int B_WEL  = 1;
   localparam int B_SRP0 = 7;
   localparam int B_SRP1 = 8;
   localparam int B_QE   = 9;
   localparam int B_CMP  = 14;
   // bits a status write never touches
   localparam logic [SR_W-1:0] FIXED_MASK = 16'h8403;

   typedef enum logic [1:0] {
      LEN_BAD = 2'd0,
      LEN_ONE = 2'd1,
      LEN_TWO = 2'd2
   } wr_len_e;

   function automatic logic hw_locked(input logic srp1, input logic srp0, input logic wp_n);
      return !srp1 && srp0 && !wp_n;
   endfunction

   function automatic int nib_base(input int slot);
      return ((slot % 2) == 0 ? 4 : 0) + (slot / 2) * 8;
   endfunction
endpackage

// File: rtl/srw_frame_rx.sv
module srw_frame_rx #(
   parameter int OP_W  = 8,
   parameter int DAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             qpi,
   input  logic [3:0]       io,
   output logic [OP_W-1:0]  op_o,
   output logic [DAT_W-1:0] data_o,
   output logic [5:0]       nbits_o,
   output logic             rise_o
);
   import srw_pkg::*;

   localparam int          NIBS  = DAT_W / 4;
   localparam logic [5:0]  OPEND = 6'(OP_W);
   localparam logic [5:0]  DEND  = 6'(OP_W + DAT_W);
   localparam logic [5:0]  SAT   = 6'd32;

   if (DAT_W != 16) begin : g_bad_width
      $error("srw_frame_rx: DAT_W must be 16");
   end
   if (OP_W != 8) begin : g_bad_op
      $error("srw_frame_rx: OP_W must be 8");
   end

   logic             cs_q;
   logic [5:0]       nbits_q;
   logic [OP_W-1:0]  op_q;
   logic [DAT_W-1:0] data_q;
   logic [NIBS-1:0]  nib_hit;
   logic [5:0]       k_idx;
   logic [3:0]       spi_pos;
   logic [5:0]       step;

   for (genvar j = 0; j < NIBS; j++) begin : g_nib
      localparam logic [5:0] AT = 6'(OP_W + 4 * j);
      assign nib_hit[j] = qpi && (nbits_q == AT);
   end

   assign k_idx   = nbits_q - OPEND;
   assign spi_pos = (k_idx < 6'd8) ? 4'(6'd7 - k_idx) : 4'(6'd23 - k_idx);
   assign step    = qpi ? 6'd4 : 6'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= 1'b1;
         nbits_q <= '0;
         op_q    <= '0;
         data_q  <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n) begin
            nbits_q <= '0;
            op_q    <= '0;
            data_q  <= '0;
         end else begin
            if (nbits_q < SAT) nbits_q <= nbits_q + step;
            if (nbits_q < OPEND) begin
               op_q <= qpi ? {op_q[OP_W-5:0], io} : {op_q[OP_W-2:0], io[0]};
            end else if (!qpi && nbits_q < DEND) begin
               data_q[spi_pos] <= io[0];
            end
            for (int j = 0; j < NIBS; j++) begin
               if (nib_hit[j]) data_q[nib_base(j) +: 4] <= io;
            end
         end
      end
   end

   assign op_o    = op_q;
   assign data_o  = data_q;
   assign nbits_o = nbits_q;
   assign rise_o  = cs_n && !cs_q;

   // R8: the counter never passes its saturation point
   p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nbits_q <= SAT);
   // R6: at most one nibble slot is hit per edge
   p_one_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nib_hit));
endmodule

// File: rtl/srw_commit.sv
module srw_commit #(
   parameter logic [7:0] OP_WRSR = 8'h01,
   parameter logic [7:0] OP_WREN = 8'h06
) (
   input  logic [15:0] sr_cur,
   input  logic [7:0]  op,
   input  logic [15:0] data,
   input  logic [5:0]  nbits,
   input  logic        qpi,
   input  logic        wp_n,
   output logic        wren_ok,
   output logic        wrsr_ok,
   output logic [15:0] sr_next
);
   import srw_pkg::*;

   if (OP_WRSR == OP_WREN) begin : g_op_clash
      $error("srw_commit: opcodes must differ");
   end

   wr_len_e len;
   logic    idle;
   logic    locked;

   always_comb begin
      unique case (nbits)
         6'd16:   len = LEN_ONE;
         6'd24:   len = LEN_TWO;
         default: len = LEN_BAD;
      endcase
   end

   assign idle    = !sr_cur[B_WIP];
   assign locked  = hw_locked(sr_cur[B_SRP1], sr_cur[B_SRP0], wp_n);
   assign wren_ok = idle && (op == OP_WREN) && (nbits == 6'd8);
   assign wrsr_ok = idle && (op == OP_WRSR) && sr_cur[B_WEL] && !locked && (len != LEN_BAD);

   always_comb begin
      sr_next = sr_cur;
      if (len == LEN_TWO) begin
         sr_next = (sr_cur & FIXED_MASK) | (data & ~FIXED_MASK);
      end else begin
         sr_next[7:2]   = data[7:2];
         sr_next[B_CMP] = 1'b0;
         if (!qpi) sr_next[B_QE] = 1'b0;
      end
      sr_next[B_WIP] = 1'b1;
   end
endmodule

// File: rtl/srw_busy_timer.sv
module srw_busy_timer #(
   parameter int TW_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(TW_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(TW_CYCLES - 1);

   if (TW_CYCLES < 1) begin : g_bad_tw
      $error("srw_busy_timer: TW_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   assign done_o = busy_q && (cnt_q == '0);
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start && !busy_q) begin
         cnt_q  <= LOAD;
         busy_q <= 1'b1;
      end else if (done_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R9: the remaining count stays inside the window
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);
   // R9: a finished window ends busy on the next edge
   p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start |=> !busy_q);
endmodule

// File: rtl/srw_top.sv
module srw_top #(
   parameter int         TW_CYCLES = 2000,
   parameter logic [7:0] OP_WRSR   = 8'h01,
   parameter logic [7:0] OP_WREN   = 8'h06
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        qpi_mode,
   input  logic        wp_n,
   input  logic [3:0]  io_in,
   output logic [15:0] status_o
);
   import srw_pkg::*;

   logic [7:0]      op;
   logic [15:0]     data;
   logic [5:0]      nbits;
   logic            rise;
   logic            busy;
   logic            done;
   logic            wren_ok;
   logic            wrsr_ok;
   logic [15:0]     sr_next;
   logic [15:0]     sr_cur;
   logic [SR_W-1:1] sr_q;
   logic            hpm_now;

   srw_frame_rx #(.OP_W(8), .DAT_W(SR_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .qpi(qpi_mode), .io(io_in),
      .op_o(op), .data_o(data), .nbits_o(nbits), .rise_o(rise)
   );

   assign sr_cur = {sr_q, busy};

   srw_commit #(.OP_WRSR(OP_WRSR), .OP_WREN(OP_WREN)) u_commit (
      .sr_cur(sr_cur), .op(op), .data(data), .nbits(nbits), .qpi(qpi_mode),
      .wp_n(wp_n), .wren_ok(wren_ok), .wrsr_ok(wrsr_ok), .sr_next(sr_next)
   );

   srw_busy_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(rise && wrsr_ok),
      .busy_o(busy), .done_o(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else begin
         if (done) sr_q[B_WEL] <= 1'b0;
         if (rise && wrsr_ok)      sr_q <= sr_next[SR_W-1:1];
         else if (rise && wren_ok) sr_q[B_WEL] <= 1'b1;
      end
   end

   assign status_o = sr_cur;
   assign hpm_now  = hw_locked(sr_q[B_SRP1], sr_q[B_SRP0], wp_n);

   // R9: busy only starts on a select release
   p_busy_from_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rise));
   // R9: write-enable falls together with busy
   p_wel_with_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(sr_q[B_WEL]));
   // R3: a commit needs the write-enable flag beforehand
   p_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(sr_q[B_WEL]));
   // R10: no commit while locked
   p_locked_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(hpm_now));
   // R8: commits only after 8 or 16 data bits
   p_len_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(nbits) == 6'd16 || $past(nbits) == 6'd24));
   // R11: a release while busy changes no stored field
   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rise && busy |=> $stable(sr_q[SR_W-1:2]));
   // R4: bits 15 and 10 are never altered
   p_fixed_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(sr_q[15]) && $stable(sr_q[10]));
endmodule

// File: tb/srw_top_tb_top.sv
module srw_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TW         = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        qpi_mode = 1'b0;
   logic        wp_n = 1'b1;
   logic [3:0]  io_in = 4'h0;
   logic [15:0] status_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   srw_top #(.TW_CYCLES(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .qpi_mode(qpi_mode),
      .wp_n(wp_n), .io_in(io_in), .status_o(status_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: status=%h expected=%h", req, act, exp);
      end
   endtask

   // frame; returns one clock after release so the commit is visible
   task automatic send(input bit q, input logic [7:0] op, input logic [15:0] d, input int nd);
      qpi_mode = q;
      if (!q) begin
         for (int b = 7; b >= 0; b--) begin
            @(negedge clk); cs_n = 1'b0; io_in = {3'b0, op[b]};
         end
         for (int k = 0; k < nd; k++) begin
            @(negedge clk); io_in = {3'b0, (k < 8) ? d[7 - k] : d[23 - k]};
         end
      end else begin
         @(negedge clk); cs_n = 1'b0; io_in = op[7:4];
         @(negedge clk); io_in = op[3:0];
         for (int n = 0; n < nd / 4; n++) begin
            @(negedge clk); io_in = d[(((n % 2) == 0) ? 4 : 0) + (n / 2) * 8 +: 4];
         end
      end
      @(negedge clk); cs_n = 1'b1; io_in = 4'h0;
      @(negedge clk);
   endtask

   function automatic logic [15:0] model(input logic [15:0] old, input logic [15:0] d,
                                         input bit two, input bit q);
      logic [15:0] n;
      n = old;
      n[7:2] = d[7:2];
      if (two) begin
         n[14:11] = d[14:11];
         n[9:8]   = d[9:8];
      end else begin
         n[14] = 1'b0;
         if (!q) n[9] = 1'b0;
      end
      n[0] = 1'b1;
      return n;
   endfunction

   task automatic finish_busy;
      for (int c = 0; c < 3 * TW && status_o[0]; c++) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (R9 busy never ended): status=%h expected=idle", status_o);
      summary();
   end

   initial begin
      logic [15:0] old, exp;
      bit ok, two, q;
      repeat (3) @(negedge clk);
      chk("R1 reset value", status_o, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", status_o, 16'h0000);

      // R3: write without enable
      send(1'b0, 8'h01, 16'hFFFF, 16);
      chk("R3 no enable", status_o, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R3 no busy", status_o, 16'h0000);

      // R2 single-line enable
      send(1'b0, 8'h06, 16'h0, 0);
      chk("R2 enable spi", status_o, 16'h0002);

      // R8 aborted lengths
      send(1'b0, 8'h01, 16'hFFFF, 12);
      chk("R8 spi 12 bits", status_o, 16'h0002);
      send(1'b1, 8'h01, 16'hFFFF, 4);
      chk("R8 qpi 4 bits", status_o, 16'h0002);
      send(1'b0, 8'h01, 16'hFFFF, 7);
      chk("R8 spi 7 bits", status_o, 16'h0002);

      // R4 + R9 window
      send(1'b0, 8'h01, 16'hFFFF, 16);
      chk("R4 spi 16 commit", status_o, 16'h7BFF);
      // R11: write while busy
      send(1'b0, 8'h01, 16'h0000, 16);
      chk("R11 ignored while busy", status_o, 16'h7BFF);
      finish_busy();
      chk("R9 end clears wip and wel", status_o, 16'h7BFC);

      // R9 exact window length
      send(1'b0, 8'h06, 16'h0, 0);
      send(1'b0, 8'h01, 16'h00A4, 8);
      chk("R5 spi 8 commit", status_o, 16'h39A7);
      repeat (TW - 1) @(negedge clk);
      chk("R9 busy at last window cycle", status_o, 16'h39A7);
      @(negedge clk);
      chk("R9 idle after window", status_o, 16'h39A4);

      // R7: four-line 8-bit keeps bit 9
      send(1'b1, 8'h06, 16'h0, 0);
      chk("R2 enable qpi", status_o, 16'h39A6);
      send(1'b0, 8'h01, 16'h02FC, 16);
      finish_busy();
      chk("R4 set qe", status_o, 16'h02FC);
      send(1'b1, 8'h06, 16'h0, 0);
      send(1'b1, 8'h01, 16'h0010, 8);
      finish_busy();
      chk("R7 qpi 8 keeps qe", status_o, 16'h0210);

      // R6 four-line full word
      send(1'b1, 8'h06, 16'h0, 0);
      send(1'b1, 8'h01, 16'h6A5C, 16);
      finish_busy();
      chk("R6 qpi 16 commit", status_o, 16'h6A5C);

      // R10 protect state
      send(1'b0, 8'h06, 16'h0, 0);
      send(1'b0, 8'h01, 16'h0080, 16);
      finish_busy();
      chk("R10 srp0 set", status_o, 16'h0080);
      send(1'b0, 8'h06, 16'h0, 0);
      wp_n = 1'b0;
      send(1'b0, 8'h01, 16'h00FC, 16);
      chk("R10 refused when locked", status_o, 16'h0082);
      wp_n = 1'b1;
      send(1'b0, 8'h01, 16'h00FC, 16);
      finish_busy();
      chk("R10 accepted with pin high", status_o, 16'h00FC);

      // sweep over modes, lengths, data and pin
      for (int i = 0; i < 96; i++) begin
         logic [15:0] d;
         q   = i[1];
         two = i[0];
         d   = 16'(i * 40503 + 7 * i * i + 16'h1357);
         wp_n = (i % 3) != 0;
         old = status_o;
         send(q, 8'h06, 16'h0, 0);
         chk("R2 sweep enable", status_o, old | 16'h0002);
         old = status_o;
         ok  = !(!old[8] && old[7] && !wp_n);
         exp = ok ? model(old, d, two, q) : old;
         send(q, 8'h01, d, two ? 16 : 8);
         chk(two ? (q ? "R6 sweep" : "R4 sweep") : (q ? "R7 sweep" : "R5 sweep"), status_o, exp);
         finish_busy();
         if (ok) exp = exp & 16'hFFFC;
         chk("R10 sweep settle", status_o, exp);
      end
      summary();
   end
endmodule